// File: doc/BRIEF.md
# Exception Frame Stacker

This block pushes the context that a processor saves when it enters an exception handler onto the supervisor stack. A single-cycle start command carries a frame kind, the status word to save, the return program counter (the address of the next instruction to run), an 8-bit vector number and the current supervisor stack pointer. The block then writes the frame one 16-bit word at a time through a simple memory write port with a ready handshake. Each write first moves the stack pointer down by two bytes. When the frame is complete, the block returns the new top of stack together with a one-cycle completion pulse.

There are three frame shapes. A reset request stacks nothing. The short frame holds the status word and the two halves of the program counter. The extended frame also holds a descriptor word made of a 4-bit format code and the byte offset of the vector. In memory the status word always lands on the new top of stack, with program counter high above it and program counter low above that. In the extended frame the descriptor word sits just above program counter low. The words are written starting from the highest address, so the status word is always the last write.

Top module: `exc_frame_stacker`

## Requirements
- R1: After a synchronous reset, busy_o, done_o and mem_we_o are 0 and sp_o is 0. A reset applied in the middle of a frame drops the write strobe and busy on the next cycle.
- R2: A start with kind_i = 0 (reset request) makes no memory write. done_o pulses in the cycle right after the start edge, and sp_o equals ssp_i.
- R3: kind_i = 1 (short frame) makes three writes, in this order: pc_i[15:0] at ssp_i-2, pc_i[31:16] at ssp_i-4, sr_i at ssp_i-6.
- R4: kind_i = 2 (extended frame) makes four writes, in this order: the descriptor word at ssp_i-2, pc_i[15:0] at ssp_i-4, pc_i[31:16] at ssp_i-6, sr_i at ssp_i-8.
- R5: Bits 15:12 of the descriptor word hold the format code parameter FMT_CODE (default 0). Bits 11:0 hold vec_i multiplied by 4.
- R6: A write is taken at a clock edge where mem_we_o and mem_rdy_i are both 1. Until then, mem_addr_o and mem_wdata_o stay stable and mem_we_o stays high. After a write is taken, the next address is 2 lower.
- R7: When done_o is 1, sp_o equals ssp_i-6 for a short frame and ssp_i-8 for an extended frame. This is the address of the final (status word) write.
- R8: done_o is high for exactly one cycle per accepted command. busy_o falls on the same edge at which done_o rises.
- R9: A start while busy_o is 1 is ignored. The frame in progress is neither disturbed nor repeated, and no extra done_o pulse appears.
- R10: kind_i = 3 behaves exactly like the short frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start command, taken when not busy |
| kind_i | input | 2 | Frame kind: 0 reset, 1 short, 2 extended, 3 short |
| sr_i | input | 16 | Status word to save |
| pc_i | input | 32 | Return program counter |
| vec_i | input | 8 | Vector number |
| ssp_i | input | 32 | Supervisor stack pointer before stacking |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 32 | Byte address of the word being written |
| mem_wdata_o | output | 16 | Word being written |
| mem_rdy_i | input | 1 | Memory takes the write at this edge |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 32 | Stack pointer after the last command |

## Verification
The first write strobe, with its address and data, is registered on the start edge and is visible one cycle later. Each following word appears one cycle after the edge that takes the previous one. done_o and sp_o appear one cycle after the edge that takes the status word, or one cycle after the start for a reset request. The bench drives inputs and samples outputs on the falling edge. It logs every write at the rising edge at which the write is taken, and it measures done latency in whole cycles from the start edge. A ready signal that is held off two cycles out of three stretches each write, which tests that address and data are held until accepted.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;
  localparam int WORD_W = 16;
  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_NONE  = 2'd0,
    KIND_SHORT = 2'd1,
    KIND_EXT   = 2'd2,
    KIND_ALT   = 2'd3
  } frame_kind_e;

  // number of stack words a frame kind occupies
  function automatic logic [2:0] frame_words(input logic [KIND_W-1:0] k);
    case (k)
      KIND_NONE: frame_words = 3'd0;
      KIND_EXT:  frame_words = 3'd4;
      default:   frame_words = 3'd3;
    endcase
  endfunction
endpackage

// File: rtl/exc_frame_ctx.sv
// Captures the saved context at launch and delivers one frame word per index.
// Index 0 = status word (lowest address), 1 = PC high, 2 = PC low, 3 = descriptor.
module exc_frame_ctx #(
  parameter int PC_W     = 32,
  parameter int VEC_W    = 8,
  parameter int FMT_CODE = 0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cap_en,
  input  logic [exc_frame_pkg::WORD_W-1:0]  sr_in,
  input  logic [PC_W-1:0]                   pc_in,
  input  logic [VEC_W-1:0]                  vec_in,
  input  logic [1:0]                        sel_idx,
  output logic [exc_frame_pkg::WORD_W-1:0]  word_o
);
  import exc_frame_pkg::*;
  localparam int FMT_W = 4;
  localparam int OFF_W = WORD_W - FMT_W;

  logic [WORD_W-1:0] sr_q,  sr_s;
  logic [PC_W-1:0]   pc_q,  pc_s;
  logic [VEC_W-1:0]  vec_q, vec_s;
  logic [OFF_W-1:0]  offset;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      pc_q  <= '0;
      vec_q <= '0;
    end else if (cap_en) begin
      sr_q  <= sr_in;
      pc_q  <= pc_in;
      vec_q <= vec_in;
    end
  end

  // at launch the first word is loaded straight from the inputs
  assign sr_s  = cap_en ? sr_in  : sr_q;
  assign pc_s  = cap_en ? pc_in  : pc_q;
  assign vec_s = cap_en ? vec_in : vec_q;
  assign offset = OFF_W'(vec_s) << 2;

  always_comb begin
    case (sel_idx)
      2'd0:    word_o = sr_s;
      2'd1:    word_o = pc_s[PC_W-1 -: WORD_W];
      2'd2:    word_o = pc_s[WORD_W-1:0];
      default: word_o = {FMT_W'(FMT_CODE), offset};
    endcase
  end
endmodule

// File: rtl/exc_frame_seq.sv
// Write sequencer: pre-decrements the stack pointer and issues one word per handshake.
module exc_frame_seq #(
  parameter int ADDR_W = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start_i,
  input  logic [exc_frame_pkg::KIND_W-1:0]  kind_i,
  input  logic [ADDR_W-1:0]                 ssp_i,
  input  logic [exc_frame_pkg::WORD_W-1:0]  word_i,
  input  logic                              mem_rdy_i,
  output logic                              cap_en,
  output logic [1:0]                        sel_idx,
  output logic                              mem_we_o,
  output logic [ADDR_W-1:0]                 mem_addr_o,
  output logic [exc_frame_pkg::WORD_W-1:0]  mem_wdata_o,
  output logic                              busy_o,
  output logic                              done_o,
  output logic [ADDR_W-1:0]                 sp_o
);
  import exc_frame_pkg::*;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

  logic              busy_q, we_q, done_q;
  logic [1:0]        idx_q;
  logic [ADDR_W-1:0] addr_q, sp_q;
  logic [WORD_W-1:0] wdata_q;
  logic [2:0]        n_words;
  logic              launch, accept;

  always_comb begin
    n_words = frame_words(kind_i);
    launch  = start_i & ~busy_q;
    accept  = busy_q & we_q & mem_rdy_i;
    cap_en  = launch;
    sel_idx = launch ? 2'(n_words - 3'd1) : idx_q - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      sp_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        if (n_words == 3'd0) begin
          done_q <= 1'b1;
          sp_q   <= ssp_i;
        end else begin
          busy_q  <= 1'b1;
          we_q    <= 1'b1;
          idx_q   <= sel_idx;
          addr_q  <= ssp_i - STEP;
          wdata_q <= word_i;
        end
      end else if (accept) begin
        if (idx_q == 2'd0) begin
          busy_q <= 1'b0;
          we_q   <= 1'b0;
          done_q <= 1'b1;
          sp_q   <= addr_q;
        end else begin
          idx_q   <= sel_idx;
          addr_q  <= addr_q - STEP;
          wdata_q <= word_i;
        end
      end
    end
  end

  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign sp_o        = sp_q;

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (we_q && !mem_rdy_i) |=> (we_q && $stable(addr_q) && $stable(wdata_q)));

  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (we_q && mem_rdy_i) |=> (!we_q || addr_q == $past(addr_q) - STEP));

  p_final_sp_r7: assert property (@(posedge clk) disable iff (rst)
    (done_q && $past(busy_q)) |-> (sp_q == $past(addr_q)));

  p_one_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  p_no_stack_r2: assert property (@(posedge clk) disable iff (rst)
    (done_q && !$past(busy_q)) |-> !$past(we_q));

  p_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i && !mem_rdy_i) |=> (busy_q && $stable(addr_q)));
endmodule

// File: rtl/exc_frame_stacker.sv
module exc_frame_stacker #(
  parameter int ADDR_W   = 32,
  parameter int VEC_W    = 8,
  parameter int FMT_CODE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        kind_i,
  input  logic [15:0]       sr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [ADDR_W-1:0] ssp_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic              mem_rdy_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] sp_o
);
  logic        cap_en;
  logic [1:0]  sel_idx;
  logic [15:0] word;

  exc_frame_ctx #(.PC_W(ADDR_W), .VEC_W(VEC_W), .FMT_CODE(FMT_CODE)) u_ctx (
    .clk(clk), .rst(rst), .cap_en(cap_en), .sr_in(sr_i), .pc_in(pc_i),
    .vec_in(vec_i), .sel_idx(sel_idx), .word_o(word)
  );

  exc_frame_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .kind_i(kind_i), .ssp_i(ssp_i),
    .word_i(word), .mem_rdy_i(mem_rdy_i), .cap_en(cap_en), .sel_idx(sel_idx),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .busy_o(busy_o), .done_o(done_o), .sp_o(sp_o)
  );

  p_idle_quiet_r1: assert property (@(posedge clk) rst |=> (!mem_we_o && !busy_o && !done_o));
endmodule

// File: tb/sim_exc_frame_stacker.sv
module sim_exc_frame_stacker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] kind = '0;
  logic [15:0] sr = '0;
  logic [31:0] pc = '0, ssp = '0;
  logic [7:0] vec = '0;
  logic mem_we, mem_rdy, busy, done;
  logic [31:0] mem_addr, sp;
  logic [15:0] mem_wdata;
  logic stall_mode = 1'b0;
  int cyc = 0;
  int total = 0, bad = 0;
  int log_n = 0, done_n = 0;
  bit finished = 1'b0;
  logic [31:0] log_addr [64];
  logic [15:0] log_data [64];

  always #5 clk = ~clk;

  exc_frame_stacker u0 (
    .clk(clk), .rst(rst), .start_i(start), .kind_i(kind), .sr_i(sr), .pc_i(pc),
    .vec_i(vec), .ssp_i(ssp), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdy_i(mem_rdy), .busy_o(busy), .done_o(done),
    .sp_o(sp)
  );

  always @(negedge clk) cyc <= cyc + 1;
  assign mem_rdy = !stall_mode || (cyc % 3 == 2);

  always @(posedge clk) begin
    if (mem_we && mem_rdy) begin
      log_addr[log_n % 64] <= mem_addr;
      log_data[log_n % 64] <= mem_wdata;
      log_n <= log_n + 1;
    end
    if (done) done_n <= done_n + 1;
  end

  typedef struct packed {
    logic [1:0]  k;
    logic [15:0] s;
    logic [31:0] p;
    logic [7:0]  v;
    logic [31:0] sp0;
    logic        st;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{2'd1, 16'h2700, 32'h0001_2346, 8'd4,   32'h0000_1000, 1'b0},
    '{2'd2, 16'h2015, 32'hDEAD_BEEA, 8'hFF,  32'h00FF_FFF0, 1'b0},
    '{2'd0, 16'h2700, 32'h0000_0400, 8'd0,   32'h0000_8000, 1'b0},
    '{2'd3, 16'hA5C3, 32'h8000_0002, 8'd25,  32'h0000_0100, 1'b0},
    '{2'd2, 16'h0000, 32'h1234_5678, 8'd64,  32'h0000_0008, 1'b1},
    '{2'd1, 16'hFFFF, 32'hFFFF_FFFE, 8'd128, 32'h7FFF_FFFE, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int i, input logic [15:0] s,
                                           input logic [31:0] p, input logic [7:0] v);
    case (i)
      0: exp_word = s;
      1: exp_word = p[31:16];
      2: exp_word = p[15:0];
      default: exp_word = {4'h0, 2'b00, v, 2'b00};
    endcase
  endfunction

  task automatic run_one(input vec_t t);
    int base, lat, n, d0;
    base = log_n; d0 = done_n;
    n = (t.k == 2'd0) ? 0 : (t.k == 2'd2) ? 4 : 3;
    @(negedge clk);
    kind = t.k; sr = t.s; pc = t.p; vec = t.v; ssp = t.sp0; stall_mode = t.st; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    chk(done == 1'b1, "R8 done seen", 32'(done), 32'd1);
    chk(busy == 1'b0, "R8 busy low with done", 32'(busy), 32'd0);
    if (t.k == 2'd0) chk(lat == 1, "R2 reset-kind latency", 32'(lat), 32'd1);
    chk(log_n - base == n, (t.k == 2'd2) ? "R4 write count" : (t.k == 2'd0) ? "R2 no write" :
        (t.k == 2'd3) ? "R10 write count" : "R3 write count", 32'(log_n - base), 32'(n));
    for (int j = 0; j < n && j < log_n - base; j++) begin
      chk(log_addr[(base + j) % 64] == t.sp0 - 32'(2 * (j + 1)), "R3 R4 R6 write address",
          log_addr[(base + j) % 64], t.sp0 - 32'(2 * (j + 1)));
      chk(log_data[(base + j) % 64] == exp_word(n - 1 - j, t.s, t.p, t.v),
          (n - 1 - j == 3) ? "R5 descriptor word" : "R3 R4 R10 write data",
          32'(log_data[(base + j) % 64]), 32'(exp_word(n - 1 - j, t.s, t.p, t.v)));
    end
    chk(sp == t.sp0 - 32'(2 * n), "R7 final sp", sp, t.sp0 - 32'(2 * n));
    @(negedge clk);
    chk(done == 1'b0, "R8 single pulse", 32'(done), 32'd0);
    chk(done_n - d0 == 1, "R8 one done per command", 32'(done_n - d0), 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && mem_we == 0, "R1 reset outputs", {29'd0, busy, done, mem_we}, 32'd0);
    chk(sp == 32'd0, "R1 reset sp", sp, 32'd0);

    foreach (TBL[i]) run_one(TBL[i]);

    // R9 start ignored while busy
    begin
      int base, d0, lat;
      vec_t t;
      t = TBL[1];
      base = log_n; d0 = done_n;
      @(negedge clk);
      kind = 2'd2; sr = t.s; pc = t.p; vec = t.v; ssp = t.sp0; stall_mode = 1'b1; start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      kind = 2'd0; sr = 16'h1111; pc = 32'h2222_2222; vec = 8'h33; ssp = 32'h4444_4444; start = 1'b1;
      @(negedge clk); start = 1'b0;
      lat = 0;
      while (!done && lat < 200) begin @(negedge clk); lat++; end
      chk(log_n - base == 4, "R9 write count unchanged", 32'(log_n - base), 32'd4);
      chk(log_addr[base % 64] == t.sp0 - 32'd2, "R9 first address kept", log_addr[base % 64], t.sp0 - 32'd2);
      chk(log_data[(base + 3) % 64] == t.s, "R9 status word kept", 32'(log_data[(base + 3) % 64]), 32'(t.s));
      chk(sp == t.sp0 - 32'd8, "R9 final sp", sp, t.sp0 - 32'd8);
      repeat (4) @(negedge clk);
      chk(done_n - d0 == 1, "R9 no extra done", 32'(done_n - d0), 32'd1);
    end

    // R1 reset during a frame
    @(negedge clk);
    kind = 2'd1; ssp = 32'h0000_2000; stall_mode = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R6 busy while stalled", 32'(busy), 32'd1);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(mem_we == 0 && busy == 0, "R1 abort on reset", {30'd0, mem_we, busy}, 32'd0);
    stall_mode = 1'b0;
    run_one(TBL[0]);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule